// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

A pipelined multiply-accumulate datapath. Two operands of independent parameterised widths are multiplied. A per-operand control chosen each cycle says whether that operand is two's complement or unsigned. The product is added to or subtracted from a running accumulator of parameterised width.

A load control restarts the accumulation from the current product. In add mode the seed is the product itself. In subtract mode the seed is the negated product. A sticky flag reports signed overflow of the accumulator.

Operands and controls are registered in one input stage, and the accumulator updates on the next edge, so a result appears two enabled clock edges after its operands are applied. A single clock enable gates every register. An active-low asynchronous reset zeroes all state.

Top module: `mac_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` and `overflow_o` are 0, asynchronously.
- R2: With `sign_a_i` = 1, `a_i` is read as two's complement; with `sign_a_i` = 0, it is read as unsigned.
- R3: With `sign_b_i` = 1, `b_i` is read as two's complement; with `sign_b_i` = 0, it is read as unsigned.
- R4: With `add_i` = 1 and `load_i` = 0, the product is added to the accumulator, modulo 2^ACC_W.
- R5: With `add_i` = 0 and `load_i` = 0, the product is subtracted from the accumulator, modulo 2^ACC_W.
- R6: With `load_i` = 1 and `add_i` = 1, the accumulator becomes the product. The previous value is discarded.
- R7: With `load_i` = 1 and `add_i` = 0, the accumulator becomes the negated product, in ACC_W-bit two's complement.
- R8: Inputs sampled on an enabled edge show up on `result_o` after the second enabled edge. After the first edge, `result_o` is unchanged.
- R9: While `en_i` is low, no register changes: `result_o` and `overflow_o` hold, and all input values are ignored. Operands already captured are applied once the enable returns.
- R10: `overflow_o` goes to 1 when an accumulate step leaves the signed ACC_W-bit range. It then stays at 1 through later non-load steps.
- R11: A load clears `overflow_o`, unless negating the product itself overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all registers |
| a_i | input | A_W | Operand A |
| b_i | input | B_W | Operand B |
| sign_a_i | input | 1 | 1: A is signed, 0: A is unsigned |
| sign_b_i | input | 1 | 1: B is signed, 0: B is unsigned |
| add_i | input | 1 | 1: add product, 0: subtract product |
| load_i | input | 1 | 1: seed the accumulator from the product |
| result_o | output | ACC_W | Accumulator value |
| overflow_o | output | 1 | Sticky signed overflow flag |

## Verification
The assertions assume that reset is applied before the first enabled edge. They also assume that the clock enable and all data inputs are settled at each rising edge, so that the registered product and controls they compare against are the values the accumulator used. The stimulus follows both rules. It holds reset at the start and changes every input only on the falling edge. It returns to an idle pattern between scenarios: enable high, zero operands, add mode, no load. Adding a zero product disturbs neither the result nor the overflow flag.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } acc_op_e;
endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           sign_a_i,
  input  logic           sign_b_i,
  input  logic           add_i,
  input  logic           load_i,
  output logic [A_W-1:0] a_o,
  output logic [B_W-1:0] b_o,
  output logic           sign_a_o,
  output logic           sign_b_o,
  output logic           add_o,
  output logic           load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o      <= '0;
      b_o      <= '0;
      sign_a_o <= 1'b0;
      sign_b_o <= 1'b0;
      add_o    <= 1'b0;
      load_o   <= 1'b0;
    end else if (en_i) begin
      a_o      <= a_i;
      b_o      <= b_i;
      sign_a_o <= sign_a_i;
      sign_b_o <= sign_b_i;
      add_o    <= add_i;
      load_o   <= load_i;
    end
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int ACC_W = 20
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int PW = A_W + B_W + 2;

  logic signed [A_W:0]  a_x;
  logic signed [B_W:0]  b_x;
  logic signed [PW-1:0] prod;

  // one extra bit lets one signed multiplier serve all sign mixes
  assign a_x  = $signed({sign_a_i & a_i[A_W-1], a_i});
  assign b_x  = $signed({sign_b_i & b_i[B_W-1], b_i});
  assign prod = PW'(a_x) * PW'(b_x);

  generate
    if (ACC_W > PW) begin : g_wide
      assign prod_o = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end else if (ACC_W == PW) begin : g_equal
      assign prod_o = prod;
    end else begin : g_narrow
      assign prod_o = prod[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] prod_i,
  input  logic             add_i,
  input  logic             load_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam int M = ACC_W - 1;

  acc_op_e          op;
  logic [ACC_W-1:0] base, nxt;
  logic             step_ovf, ovf_d;

  assign op   = acc_op_e'(add_i);
  // a load behaves as an accumulate onto zero
  assign base = load_i ? '0 : acc_o;
  assign nxt  = (op == OP_ADD) ? base + prod_i : base - prod_i;

  always_comb begin
    if (op == OP_ADD) step_ovf = (base[M] == prod_i[M]) && (nxt[M] != base[M]);
    else              step_ovf = (base[M] != prod_i[M]) && (nxt[M] != base[M]);
    ovf_d = (load_i ? 1'b0 : ovf_o) | step_ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (en_i) begin
      acc_o <= nxt;
      ovf_o <= ovf_d;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic             add_i,
  input  logic             load_i,
  output logic [ACC_W-1:0] result_o,
  output logic             overflow_o
);
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic             sa_q, sb_q, add_q, ld_q;
  logic [ACC_W-1:0] prod_acc;

  mac_in_stage #(.A_W(A_W), .B_W(B_W)) in_i (
    .clk_i, .rst_ni, .en_i,
    .a_i, .b_i, .sign_a_i, .sign_b_i, .add_i, .load_i,
    .a_o(a_q), .b_o(b_q), .sign_a_o(sa_q), .sign_b_o(sb_q),
    .add_o(add_q), .load_o(ld_q)
  );

  mac_mult #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) mul_i (
    .a_i(a_q), .b_i(b_q), .sign_a_i(sa_q), .sign_b_i(sb_q),
    .prod_o(prod_acc)
  );

  mac_accum #(.ACC_W(ACC_W)) acc_i (
    .clk_i, .rst_ni, .en_i,
    .prod_i(prod_acc), .add_i(add_q), .load_i(ld_q),
    .acc_o(result_o), .ovf_o(overflow_o)
  );
endmodule

module mac_unit_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             ld_q,
  input logic             add_q,
  input logic [ACC_W-1:0] prod_i,
  input logic [ACC_W-1:0] result_o,
  input logic             overflow_o
);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(result_o) && $stable(overflow_o)));

  // R10
  sticky_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && overflow_o && !ld_q) |=> overflow_o);

  // R6
  load_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_q && add_q) |=> (result_o == $past(prod_i)));

  // R7
  load_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_q && !add_q) |=> (result_o == ACC_W'(ACC_W'(0) - $past(prod_i))));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_zero_chk: assert (result_o == '0 && !overflow_o);
    end
  end
endmodule

bind mac_unit mac_unit_chk #(.ACC_W(ACC_W)) chk_i (
  .clk_i, .rst_ni, .en_i, .ld_q, .add_q,
  .prod_i(prod_acc), .result_o, .overflow_o
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int A_W   = 8;
  localparam int B_W   = 8;
  localparam int ACC_W = 20;
  localparam longint LIM = longint'(1) <<< (ACC_W - 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic [A_W-1:0] a = '0;
  logic [B_W-1:0] b = '0;
  logic sa = 1'b0, sb = 1'b0, add = 1'b1, ld = 1'b0;
  logic [ACC_W-1:0] result;
  logic ovf;

  int checks = 0;
  int errors = 0;
  longint exp_acc = 0;
  bit exp_ovf = 1'b0;
  longint old_acc = 0;
  bit old_ovf = 1'b0;

  always #2 clk = ~clk;

  mac_unit #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .a_i(a), .b_i(b),
    .sign_a_i(sa), .sign_b_i(sb), .add_i(add), .load_i(ld),
    .result_o(result), .overflow_o(ovf)
  );

  function automatic longint wrap(longint v);
    logic [ACC_W-1:0] t;
    t = v[ACC_W-1:0];
    return longint'($signed(t));
  endfunction

  task automatic check(string tag, longint e_acc, bit e_ovf);
    logic [ACC_W-1:0] e;
    e = e_acc[ACC_W-1:0];
    checks++;
    if (result !== e || ovf !== e_ovf) begin
      errors++;
      $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", tag, result, ovf, e, e_ovf);
    end
  endtask

  // apply one operation and advance the model
  task automatic op(logic [A_W-1:0] av, logic [B_W-1:0] bv, bit s_a, bit s_b, bit ad, bit lo);
    longint pa, pb, p, raw;
    @(negedge clk);
    en = 1'b1; a = av; b = bv; sa = s_a; sb = s_b; add = ad; ld = lo;
    pa = s_a ? longint'($signed(av)) : longint'(av);
    pb = s_b ? longint'($signed(bv)) : longint'(bv);
    p = pa * pb;
    old_acc = exp_acc; old_ovf = exp_ovf;
    if (lo) begin
      raw = ad ? p : -p;
      exp_ovf = 1'b0;
    end else begin
      raw = ad ? exp_acc + p : exp_acc - p;
    end
    if (raw >= LIM || raw < -LIM) exp_ovf = 1'b1;
    exp_acc = wrap(raw);
  endtask

  task automatic idle();
    @(negedge clk);
    en = 1'b1; a = '0; b = '0; sa = 1'b0; sb = 1'b0; add = 1'b1; ld = 1'b0;
  endtask

  task automatic settle();
    idle();
    idle();
  endtask

  task automatic t_reset();
    check("R1 reset", 0, 1'b0);
  endtask

  task automatic t_load_latency();
    op(8'd3, 8'd5, 1'b0, 1'b0, 1'b1, 1'b1);
    idle();
    check("R8 one edge unchanged", old_acc, old_ovf);
    idle();
    check("R8 R6 load add", exp_acc, exp_ovf);
  endtask

  task automatic t_signs();
    op(8'hFE, 8'd3, 1'b1, 1'b0, 1'b1, 1'b1); settle();
    check("R2 signed A", exp_acc, exp_ovf);
    op(8'hFE, 8'd3, 1'b0, 1'b0, 1'b1, 1'b1); settle();
    check("R2 unsigned A", exp_acc, exp_ovf);
    op(8'd5, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1); settle();
    check("R3 signed B", exp_acc, exp_ovf);
    op(8'd5, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1); settle();
    check("R3 unsigned B", exp_acc, exp_ovf);
    op(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1); settle();
    check("R2 R3 both signed", exp_acc, exp_ovf);
  endtask

  task automatic t_add_sub();
    op(8'd10, 8'd10, 1'b0, 1'b0, 1'b1, 1'b1);
    op(8'd7, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0); settle();
    check("R4 add", exp_acc, exp_ovf);
    op(8'd50, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0); settle();
    check("R5 sub", exp_acc, exp_ovf);
    op(8'h80, 8'd2, 1'b1, 1'b0, 1'b0, 1'b0); settle();
    check("R5 sub negative product", exp_acc, exp_ovf);
  endtask

  task automatic t_load_sub();
    op(8'd4, 8'd6, 1'b0, 1'b0, 1'b0, 1'b1); settle();
    check("R7 load sub", exp_acc, exp_ovf);
  endtask

  task automatic t_enable();
    op(8'd9, 8'd9, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      en = 1'b0; a = 8'd77; b = 8'd77; ld = 1'b1; add = 1'b0;
      check("R9 hold while disabled", old_acc, old_ovf);
    end
    settle();
    check("R9 pending op applied", exp_acc, exp_ovf);
  endtask

  task automatic t_overflow();
    op(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) op(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0);
    settle();
    check("R10 in range", exp_acc, exp_ovf);
    op(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0); settle();
    check("R10 overflow set", exp_acc, exp_ovf);
    op(8'd1, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0); settle();
    check("R10 sticky", exp_acc, exp_ovf);
    op(8'd2, 8'd2, 1'b0, 1'b0, 1'b1, 1'b1); settle();
    check("R11 load clears", exp_acc, exp_ovf);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    idle();
    t_reset();
    t_load_latency();
    t_signs();
    t_add_sub();
    t_load_sub();
    t_enable();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule